// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects up to sixteen peripheral request lines and presents them to a processor as a 3-bit interrupt priority level. Each line has its own control byte that selects the level it raises, whether it is enabled, whether it is sensed as a level or as a latched edge, and which polarity counts as active. Every request line first passes through a synchroniser. A global enable bit and a per-level mask register apply on top of the per-source settings.

The processor acknowledges an interrupt by pulsing `iack` with the level it is serving. One cycle later the block returns an 8-bit vector: a programmable base plus the 4-bit code of the winning source. The source code also sets the priority, and the highest code wins among pending sources at the acknowledged level. If nothing at that level is pending, the block flags the acknowledge as spurious.

Software uses a simple synchronous byte port. The registers are: global control at 0x00 (bit 1 is the master enable), vector base at 0x01, level mask at 0x02 (bit L blocks level L), current priority level at 0x03 (read-only), and one control byte per source at 0x10 plus the source code.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset `ipl` is 0, `ack_vld` and `ack_spur` are 0, and the control, base, mask and all source bytes read 0.
- R2: Each source byte reads back with these bits: level in [2:0], enable in bit 4, edge select in bit 6 and polarity in bit 7. Bit 3 always reads 0, and bit 5 reads the source's active status.
- R3: In level mode (bit 6 = 0) the active status follows the synchronised input: high when the input is 1 with polarity 0, and high when the input is 0 with polarity 1.
- R4: In edge mode (bit 6 = 1) the selected edge sets a latched request. The request stays set after the input returns. It is cleared only by writing the source byte with bit 3 = 1.
- R5: `ipl` equals the highest level among requesting sources. A source whose level field is 0 never requests, even when it is enabled and active.
- R6: When the master enable (bit 1 of register 0x00) is 0, `ipl` is 0 and every acknowledge is spurious.
- R7: A set bit L in the mask register (0x02) stops every source at level L from requesting, for both `ipl` and acknowledge.
- R8: `iack` sampled high on a clock edge gives `ack_vld` high for exactly the following cycle. At that point `ack_vec` = base + the code of the highest-coded requesting source at level `iack_lvl`.
- R9: If no source requests at the acknowledged level, `ack_spur` is 1 with `ack_vld`, and `ack_vec` equals the base value.
- R10: The vector sum wraps modulo 256. For example, base 0xF8 plus code 12 gives 0x04.
- R11: A source with enable bit 4 = 0 does not affect `ipl` or acknowledge, but its active status still reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational on `reg_addr`) |
| irq_in | input | NSRC | Asynchronous peripheral request lines |
| ipl | output | 3 | Priority level presented to the processor |
| iack | input | 1 | Acknowledge strobe |
| iack_lvl | input | 3 | Level being acknowledged |
| ack_vec | output | 8 | Acknowledge vector |
| ack_vld | output | 1 | Vector valid, one cycle after `iack` |
| ack_spur | output | 1 | Acknowledge found no pending source |

## Verification
The bound checker watches four things on every cycle:
- the master enable forcing the level to zero;
- the presented level never being a masked one;
- the one-cycle acknowledge response, with the spurious flag only ever qualified by it;
- latched edge requests holding until a clear write.

Only the bench scenarios can show the rest:
- polarity handling and the synchroniser delay;
- level-zero and disabled sources;
- which source wins among equal-level candidates;
- the exact vector arithmetic, including wrap-around.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
   localparam int LVL_W   = 3;
   localparam int CODE_W  = 4;
   localparam int BYTE_W  = 8;
   localparam int SRC_OFS = 16;

   // register addresses below the source block
   localparam int A_CTRL = 0;
   localparam int A_BASE = 1;
   localparam int A_MASK = 2;
   localparam int A_LVL  = 3;

   // source byte bit positions
   localparam int B_CLR = 3;
   localparam int B_EN  = 4;
   localparam int B_ACT = 5;
   localparam int B_EDG = 6;
   localparam int B_POL = 7;
   localparam int B_MEN = 1;

   typedef struct packed {
      logic             pol;
      logic             edg;
      logic             en;
      logic [LVL_W-1:0] lvl;
   } src_cfg_t;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
   import irq_vec_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_in,
   input  logic              wr,
   input  logic [BYTE_W-1:0] wdata,
   output src_cfg_t          cfg,
   output logic              active,
   output logic              clr_hit
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   latch_q;
   logic                   now_on;
   logic                   was_on;
   logic                   edge_hit;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("irq_src_cell: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], req_in};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign clr_hit  = wr & wdata[B_CLR];
   assign now_on   = sync_q[SYNC_STAGES-1] ^ cfg.pol;
   assign was_on   = prev_q ^ cfg.pol;
   assign edge_hit = now_on & ~was_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (wr) begin
         cfg.pol <= wdata[B_POL];
         cfg.edg <= wdata[B_EDG];
         cfg.en  <= wdata[B_EN];
         cfg.lvl <= wdata[LVL_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          latch_q <= 1'b0;
      else if (!cfg.edg)   latch_q <= 1'b0;
      else if (edge_hit)   latch_q <= 1'b1;
      else if (clr_hit)    latch_q <= 1'b0;
   end

   assign active = cfg.edg ? latch_q : now_on;
endmodule

// File: rtl/irq_prio_merge.sv
module irq_prio_merge
   import irq_vec_pkg::*;
#(
   parameter int NSRC = 16
) (
   input  logic [NSRC-1:0]       req,
   input  logic [NSRC*LVL_W-1:0] lvl_flat,
   input  logic [LVL_W-1:0]      sel_lvl,
   output logic [LVL_W-1:0]      top_lvl,
   output logic [CODE_W-1:0]     win_code,
   output logic                  win_found
);
   always_comb begin
      top_lvl   = '0;
      win_code  = '0;
      win_found = 1'b0;
      for (int i = 0; i < NSRC; i++) begin
         if (req[i]) begin
            if (lvl_flat[i*LVL_W +: LVL_W] > top_lvl)
               top_lvl = lvl_flat[i*LVL_W +: LVL_W];
            if (lvl_flat[i*LVL_W +: LVL_W] == sel_lvl) begin
               win_code  = CODE_W'(i);
               win_found = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
   import irq_vec_pkg::*;
#(
   parameter int NSRC        = 16,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic [NSRC-1:0]   irq_in,
   output logic [2:0]        ipl,
   input  logic              iack,
   input  logic [2:0]        iack_lvl,
   output logic [7:0]        ack_vec,
   output logic              ack_vld,
   output logic              ack_spur
);
   localparam int MASK_W = 1 << LVL_W;

   generate
      if (NSRC < 1 || NSRC > (1 << CODE_W)) begin : g_bad_nsrc
         $error("irq_vec_ctrl: NSRC out of range");
      end
      if (SRC_OFS + NSRC > (1 << ADDR_W)) begin : g_bad_addr
         $error("irq_vec_ctrl: ADDR_W too small");
      end
   endgenerate

   logic                  men_q;
   logic [BYTE_W-1:0]     base_q;
   logic [MASK_W-1:0]     mask_q;
   src_cfg_t              cfg_v [NSRC];
   logic [NSRC-1:0]       act_v, clr_v, edg_v, req_v, we_v;
   logic [NSRC*LVL_W-1:0] lvl_flat;
   logic [LVL_W-1:0]      top_lvl;
   logic [CODE_W-1:0]     win_code;
   logic                  win_found;

   genvar gi;
   generate
      for (gi = 0; gi < NSRC; gi++) begin : g_src
         assign we_v[gi] = reg_we && (reg_addr == ADDR_W'(SRC_OFS + gi));
         irq_src_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_in  (irq_in[gi]),
            .wr      (we_v[gi]),
            .wdata   (reg_wdata),
            .cfg     (cfg_v[gi]),
            .active  (act_v[gi]),
            .clr_hit (clr_v[gi])
         );
         assign edg_v[gi] = cfg_v[gi].edg;
         assign lvl_flat[gi*LVL_W +: LVL_W] = cfg_v[gi].lvl;
         assign req_v[gi] = men_q & act_v[gi] & cfg_v[gi].en &
                            (cfg_v[gi].lvl != '0) & ~mask_q[cfg_v[gi].lvl];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         men_q  <= 1'b0;
         base_q <= '0;
         mask_q <= '0;
      end else if (reg_we) begin
         if (reg_addr == ADDR_W'(A_CTRL)) men_q  <= reg_wdata[B_MEN];
         if (reg_addr == ADDR_W'(A_BASE)) base_q <= reg_wdata;
         if (reg_addr == ADDR_W'(A_MASK)) mask_q <= {reg_wdata[MASK_W-1:1], 1'b0};
      end
   end

   irq_prio_merge #(.NSRC(NSRC)) u_merge (
      .req       (req_v),
      .lvl_flat  (lvl_flat),
      .sel_lvl   (iack_lvl),
      .top_lvl   (top_lvl),
      .win_code  (win_code),
      .win_found (win_found)
   );

   assign ipl = top_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_vec  <= '0;
         ack_vld  <= 1'b0;
         ack_spur <= 1'b0;
      end else begin
         ack_vld  <= iack;
         ack_spur <= iack & ~win_found;
         if (iack) ack_vec <= base_q + {{(BYTE_W-CODE_W){1'b0}}, win_code};
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(A_CTRL)) reg_rdata[B_MEN] = men_q;
      if (reg_addr == ADDR_W'(A_BASE)) reg_rdata = base_q;
      if (reg_addr == ADDR_W'(A_MASK)) reg_rdata = mask_q;
      if (reg_addr == ADDR_W'(A_LVL))  reg_rdata = {5'b0, top_lvl};
      for (int i = 0; i < NSRC; i++) begin
         if (reg_addr == ADDR_W'(SRC_OFS + i))
            reg_rdata = {cfg_v[i].pol, cfg_v[i].edg, act_v[i], cfg_v[i].en,
                         1'b0, cfg_v[i].lvl};
      end
   end
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
   parameter int NSRC = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            men,
   input logic [7:0]      mask,
   input logic [2:0]      ipl,
   input logic            iack,
   input logic            ack_vld,
   input logic            ack_spur,
   input logic [NSRC-1:0] act,
   input logic [NSRC-1:0] clr,
   input logic [NSRC-1:0] edg
);
   // R6
   men_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !men |-> ipl == 3'd0);
   // R7
   mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ipl != 3'd0 |-> !mask[ipl]);
   // R8
   ack_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iack |=> ack_vld);
   // R8
   no_unsolicited_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !iack |=> !ack_vld);
   // R9
   spur_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_spur |-> ack_vld);
   // R4
   edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(act & ~clr & edg) & edg & ~act) == '0));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.NSRC(NSRC)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .men      (men_q),
   .mask     (mask_q),
   .ipl      (ipl),
   .iack     (iack),
   .ack_vld  (ack_vld),
   .ack_spur (ack_spur),
   .act      (act_v),
   .clr      (clr_v),
   .edg      (edg_v)
);

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;
   localparam int NSRC = 16;
   localparam int AW   = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [7:0]    reg_wdata = '0;
   logic [7:0]    reg_rdata;
   logic [NSRC-1:0] irq_in = '0;
   logic [2:0]    ipl;
   logic          iack = 1'b0;
   logic [2:0]    iack_lvl = '0;
   logic [7:0]    ack_vec;
   logic          ack_vld;
   logic          ack_spur;

   int checks = 0;
   int fails  = 0;
   logic [7:0] base_m = 8'h00;

   typedef struct {
      logic [7:0] vec;
      logic       spur;
      string      tag;
   } exp_t;
   exp_t sb_q[$];

   always #4 clk = ~clk;

   irq_vec_ctrl #(.NSRC(NSRC), .ADDR_W(AW)) u_dut (
      .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
      .irq_in, .ipl, .iack, .iack_lvl, .ack_vec, .ack_vld, .ack_spur
   );

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic wr(int a, logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
      if (a == 1) base_m = d;
   endtask

   task automatic rd_chk(string tag, int a, logic [7:0] exp);
      @(negedge clk);
      reg_addr = AW'(a);
      #1 chk(tag, reg_rdata, exp);
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   // driver: pushes the expected vector, then strobes acknowledge
   task automatic do_ack(string tag, logic [2:0] lvl, bit spur, int code);
      exp_t e;
      e.vec  = spur ? base_m : base_m + 8'(code);
      e.spur = spur;
      e.tag  = tag;
      @(negedge clk);
      sb_q.push_back(e);
      iack = 1'b1; iack_lvl = lvl;
      @(negedge clk);
      iack = 1'b0;
      @(negedge clk);
   endtask

   // monitor: pops and compares whenever the design reports a vector
   always @(negedge clk) begin
      if (ack_vld) begin
         if (sb_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL R8: unexpected vector actual %02h expected none", ack_vec);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            chk({e.tag, " vec"}, ack_vec, e.vec);
            chk({e.tag, " spur"}, {7'b0, ack_spur}, {7'b0, e.spur});
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 ipl", {5'b0, ipl}, 8'h00);
      chk("R1 vld", {7'b0, ack_vld}, 8'h00);
      rd_chk("R1 ctrl", 0, 8'h00);
      rd_chk("R1 base", 1, 8'h00);
      rd_chk("R1 src9", 16 + 9, 8'h00);
      rst_n = 1'b1;

      wr(0, 8'h02);
      wr(1, 8'h50);
      wr(16 + 9, 8'h1D);                 // bit3 set, level mode, lvl5, en
      rd_chk("R2 src9 readback", 16 + 9, 8'h15);
      irq_in[9] = 1'b1; settle();
      chk("R5 ipl src9", {5'b0, ipl}, 8'h05);
      rd_chk("R3 src9 active", 16 + 9, 8'h35);
      do_ack("R8 src9", 3'd5, 1'b0, 9);

      // R3 polarity low
      wr(16 + 9, 8'h95);
      settle();
      chk("R3 pol low input high", {5'b0, ipl}, 8'h00);
      irq_in[9] = 1'b0; settle();
      chk("R3 pol low input low", {5'b0, ipl}, 8'h05);
      wr(16 + 9, 8'h00);
      chk("R11 src9 off", {5'b0, ipl}, 8'h00);

      // R4 edge latch
      wr(16 + 3, 8'h53);
      irq_in[3] = 1'b1; settle();
      irq_in[3] = 1'b0; settle();
      rd_chk("R4 latched", 16 + 3, 8'h73);
      chk("R4 ipl latched", {5'b0, ipl}, 8'h03);
      wr(16 + 3, 8'h5B);
      rd_chk("R4 cleared", 16 + 3, 8'h53);
      chk("R4 ipl cleared", {5'b0, ipl}, 8'h00);

      // R5 level zero, R11 disabled
      wr(16 + 4, 8'h10);
      wr(16 + 5, 8'h06);
      irq_in[4] = 1'b1; irq_in[5] = 1'b1; settle();
      chk("R5 level0 no ipl", {5'b0, ipl}, 8'h00);
      rd_chk("R5 level0 active", 16 + 4, 8'h30);
      rd_chk("R11 disabled active", 16 + 5, 8'h26);

      // R5 highest level, R7 mask
      wr(16 + 2, 8'h12);
      wr(16 + 7, 8'h16);
      irq_in[2] = 1'b1; irq_in[7] = 1'b1; settle();
      chk("R5 max level", {5'b0, ipl}, 8'h06);
      rd_chk("R5 level reg", 3, 8'h06);
      wr(2, 8'h40);
      chk("R7 masked", {5'b0, ipl}, 8'h02);
      wr(2, 8'h00);
      chk("R7 unmasked", {5'b0, ipl}, 8'h06);

      // R8 highest code at a level, R9 spurious
      wr(16 + 12, 8'h16);
      irq_in[12] = 1'b1; settle();
      do_ack("R8 lvl6 code12", 3'd6, 1'b0, 12);
      do_ack("R8 lvl2 code2", 3'd2, 1'b0, 2);
      do_ack("R9 lvl4 empty", 3'd4, 1'b1, 0);

      // R6 master enable
      wr(0, 8'h00);
      chk("R6 men off", {5'b0, ipl}, 8'h00);
      do_ack("R6 ack men off", 3'd6, 1'b1, 0);
      wr(0, 8'h02);
      chk("R6 men on", {5'b0, ipl}, 8'h06);

      // R10 wrap
      wr(1, 8'hF8);
      do_ack("R10 wrap", 3'd6, 1'b0, 12);
      // R7 mask applies to acknowledge
      wr(2, 8'h40);
      do_ack("R7 ack masked", 3'd6, 1'b1, 0);

      repeat (3) @(negedge clk);
      if (sb_q.size() != 0) begin
         checks++; fails++;
         $display("FAIL R8: actual %0d pending expected 0", sb_q.size());
      end
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule